// File: doc/BRIEF.md
# Caption Start Bit Detector

This block locates the start bit of a caption data stream carried on single video lines. A digitized comparator output is watched during the clock run-in burst that follows each horizontal sync. The block counts the falling edges of the run-in pulses from the start of the line. Once the falling edge of the chosen pulse has passed, it samples the comparator on a strobe that occurs every 13 reference clocks. When the start bit is recognised it raises a start-found flag. After a programmable delay it then issues data-clock strobes that a later bit shifter can use.

The pulse choice, the detection method and the delay are software fields. The block copies them into working registers only on a falling edge of horizontal sync, so a write during a line affects only the following lines. There are two detection methods. One accepts a single high sample. The other needs two high samples in a row, which rejects a one-sample glitch.

Top module: `capt_startbit_detect`

## Requirements
- R1: While reset is asserted, and after it is released until the first horizontal sync falling edge, `start_found_o` and `dclk_o` are 0.
- R2: Falling edges of `cmp_i` are counted from 0 after each sync falling edge. The hunt arms on the clock edge at which the count reaches `pulse_sel_i` (1 to 7 = 1st to 7th run-in pulse). Samples taken before arming are ignored.
- R3: The sync falling edge is clock edge 0, the first edge at which `hsync_i` is seen low. The comparator is sampled only on edges 13, 26, 39 and so on after it.
- R4: With `method_i` = 0, the first armed sample that reads 1 sets `start_found_o` on that same edge.
- R5: With `method_i` = 1, `start_found_o` is set on the second of two consecutive armed samples that both read 1. A high sample followed by a low one restarts the pairing.
- R6: When the latched pulse select is 0, `start_found_o` and `dclk_o` stay 0 for the whole line.
- R7: The first `dclk_o` pulse is high for one cycle, 13 + N clock edges after the edge that set `start_found_o`. N is the latched `delay_i` (unsigned).
- R8: After the first pulse, `dclk_o` pulses for one cycle every 13 clocks until the next sync falling edge.
- R9: `pulse_sel_i`, `method_i` and `delay_i` are latched only at a sync falling edge. Changes made between two such edges have no effect on the current line.
- R10: A sync falling edge clears `start_found_o`, the edge count and the arming. A `dclk_o` pulse due on that same edge is suppressed.
- R11: Once set, `start_found_o` stays 1 until the next sync falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hsync_i | input | 1 | Horizontal sync, synchronous to clk; a falling edge starts a line |
| cmp_i | input | 1 | Digitized comparator output, synchronous to clk |
| pulse_sel_i | input | 3 | Run-in pulse after which the hunt starts; 0 disables the line |
| method_i | input | 1 | 0: one high sample; 1: two consecutive high samples |
| delay_i | input | DELAY_W | Extra delay N before the first data clock |
| start_found_o | output | 1 | Start bit recognised on this line |
| dclk_o | output | 1 | One-cycle data-clock strobe |

## Verification
Two events can fall on the same clock edge: a sync falling edge that ends the line, and a data-clock pulse that is still due. The bench provokes this by choosing the line length so that the next sync falls exactly 13 + N + 26 edges after detection. It then expects `dclk_o` and `start_found_o` to be 0 on that edge, while the earlier pulses of the line must still have appeared. A cycle-accurate expectation is built from the requirements for every line. It catches any off-by-one in arming, sampling or the delay.

// File: rtl/capt_sb_pkg.sv
package capt_sb_pkg;
  localparam int unsigned SAMP_DIV = 13;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned DIV_W = $clog2(SAMP_DIV);

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             method;
  } line_cfg_t;

  typedef enum logic {
    DC_IDLE   = 1'b0,
    DC_ACTIVE = 1'b1
  } dclk_state_e;
endpackage

// File: rtl/capt_sb_front.sv
module capt_sb_front
  import capt_sb_pkg::*;
#(
  parameter int unsigned DELAY_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hsync_i,
  input  logic               cmp_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               method_i,
  input  logic [DELAY_W-1:0] delay_i,
  output logic               hs_fall_o,
  output logic               run_fall_o,
  output line_cfg_t          cfg_o,
  output logic [DELAY_W-1:0] delay_o
);
  logic               hs_q, hs_d;
  logic               cmp_q, cmp_d;
  line_cfg_t          cfg_q, cfg_d;
  logic [DELAY_W-1:0] dly_q, dly_d;

  assign hs_fall_o  = hs_q & ~hsync_i;
  assign run_fall_o = cmp_q & ~cmp_i;
  assign cfg_o      = cfg_q;
  assign delay_o    = dly_q;

  always_comb begin
    hs_d  = hsync_i;
    cmp_d = cmp_i;
    cfg_d = cfg_q;
    dly_d = dly_q;
    if (hs_fall_o) begin
      cfg_d.sel    = sel_i;
      cfg_d.method = method_i;
      dly_d        = delay_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      cmp_q <= 1'b0;
      cfg_q <= '0;
      dly_q <= '0;
    end else begin
      hs_q  <= hs_d;
      cmp_q <= cmp_d;
      cfg_q <= cfg_d;
      dly_q <= dly_d;
    end
  end

  assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_fall_o |=> ($stable(cfg_q) && $stable(dly_q)));
endmodule

// File: rtl/capt_sb_hunter.sv
module capt_sb_hunter
  import capt_sb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hs_fall_i,
  input  logic      run_fall_i,
  input  logic      cmp_i,
  input  line_cfg_t cfg_i,
  output logic      hit_o,
  output logic      found_o
);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SAMP_DIV - 1);
  localparam logic [SEL_W-1:0] CNT_MAX  = '1;

  logic [DIV_W-1:0] div_q, div_d;
  logic [SEL_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             prev_q, prev_d;
  logic             found_q, found_d;
  logic             samp_stb;
  logic             reach_sel;

  assign samp_stb  = (div_q == DIV_LAST);
  assign reach_sel = (cfg_i.sel != '0) && ({1'b0, cnt_q} + 1'b1 == {1'b0, cfg_i.sel});
  assign hit_o     = samp_stb & armed_q & ~found_q & cmp_i & (~cfg_i.method | prev_q);
  assign found_o   = found_q;

  always_comb begin
    div_d   = div_q;
    cnt_d   = cnt_q;
    armed_d = armed_q;
    prev_d  = prev_q;
    found_d = found_q;
    if (hs_fall_i) begin
      div_d   = '0;
      cnt_d   = '0;
      armed_d = 1'b0;
      prev_d  = 1'b0;
      found_d = 1'b0;
    end else begin
      div_d = samp_stb ? '0 : div_q + 1'b1;
      if (run_fall_i) begin
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
        if (reach_sel) armed_d = 1'b1;
      end
      if (samp_stb && armed_q && !found_q) begin
        prev_d = cmp_i;
        if (hit_o) found_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      prev_q  <= 1'b0;
      found_q <= 1'b0;
    end else begin
      div_q   <= div_d;
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      prev_q  <= prev_d;
      found_q <= found_d;
    end
  end

  assert_found_on_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(found_q) |-> $past(samp_stb));
  assert_found_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (found_q && !hs_fall_i) |=> found_q);
  assert_sel_zero_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.sel == '0) |-> !found_q);
endmodule

// File: rtl/capt_sb_dclk.sv
module capt_sb_dclk
  import capt_sb_pkg::*;
#(
  parameter int unsigned DELAY_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hs_fall_i,
  input  logic               hit_i,
  input  logic               found_i,
  input  logic [DELAY_W-1:0] delay_i,
  output logic               dclk_o
);
  localparam int unsigned CW = $clog2(SAMP_DIV + (1 << DELAY_W));
  localparam logic [CW-1:0] LOAD_BASE = CW'(SAMP_DIV - 1);

  dclk_state_e   st_q, st_d;
  logic [CW-1:0] dcnt_q, dcnt_d;
  logic          dclk_q, dclk_d;

  assign dclk_o = dclk_q;

  always_comb begin
    st_d   = st_q;
    dcnt_d = dcnt_q;
    dclk_d = 1'b0;
    if (hs_fall_i) begin
      st_d   = DC_IDLE;
      dcnt_d = '0;
    end else begin
      unique case (st_q)
        DC_IDLE: begin
          if (hit_i) begin
            st_d   = DC_ACTIVE;
            dcnt_d = LOAD_BASE + CW'(delay_i);
          end
        end
        DC_ACTIVE: begin
          if (dcnt_q == '0) begin
            dclk_d = 1'b1;
            dcnt_d = LOAD_BASE;
          end else begin
            dcnt_d = dcnt_q - 1'b1;
          end
        end
        default: st_d = DC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DC_IDLE;
      dcnt_q <= '0;
      dclk_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      dcnt_q <= dcnt_d;
      dclk_q <= dclk_d;
    end
  end

  assert_dclk_needs_found_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_q |-> found_i);
  assert_dclk_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dclk_q |=> !dclk_q);
  assert_sync_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hs_fall_i |=> (!dclk_q && !found_i));
endmodule

// File: rtl/capt_startbit_detect.sv
module capt_startbit_detect
  import capt_sb_pkg::*;
#(
  parameter int unsigned DELAY_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hsync_i,
  input  logic               cmp_i,
  input  logic [2:0]         pulse_sel_i,
  input  logic               method_i,
  input  logic [DELAY_W-1:0] delay_i,
  output logic               start_found_o,
  output logic               dclk_o
);
  logic               rst_meta, rst_sync;
  logic               hs_fall, run_fall, hit, found;
  line_cfg_t          cfg;
  logic [DELAY_W-1:0] dly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  capt_sb_front #(.DELAY_W(DELAY_W)) u_front (
    .clk       (clk),
    .rst_n     (rst_sync),
    .hsync_i   (hsync_i),
    .cmp_i     (cmp_i),
    .sel_i     (pulse_sel_i),
    .method_i  (method_i),
    .delay_i   (delay_i),
    .hs_fall_o (hs_fall),
    .run_fall_o(run_fall),
    .cfg_o     (cfg),
    .delay_o   (dly)
  );

  capt_sb_hunter u_hunter (
    .clk       (clk),
    .rst_n     (rst_sync),
    .hs_fall_i (hs_fall),
    .run_fall_i(run_fall),
    .cmp_i     (cmp_i),
    .cfg_i     (cfg),
    .hit_o     (hit),
    .found_o   (found)
  );

  capt_sb_dclk #(.DELAY_W(DELAY_W)) u_dclk (
    .clk       (clk),
    .rst_n     (rst_sync),
    .hs_fall_i (hs_fall),
    .hit_i     (hit),
    .found_i   (found),
    .delay_i   (dly),
    .dclk_o    (dclk_o)
  );

  assign start_found_o = found;
endmodule

// File: tb/tb_capt_startbit_detect.sv
module tb_capt_startbit_detect;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          hsync_i, cmp_i, method_i;
  logic [2:0]    pulse_sel_i;
  logic [DW-1:0] delay_i;
  logic          start_found_o, dclk_o;

  always #4 clk = ~clk;

  capt_startbit_detect #(.DELAY_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .cmp_i(cmp_i),
    .pulse_sel_i(pulse_sel_i), .method_i(method_i), .delay_i(delay_i),
    .start_found_o(start_found_o), .dclk_o(dclk_o)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  int obs_found_k, obs_dclk_k, obs_dclk_n, obs_k0_found, obs_k0_dclk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit cmp_at(input int k, input int b1s, input int b1e,
                                input int b2s, input int b2e);
    bit runin;
    runin = (k >= 1) && (k < 29) && ((((k - 1) / 2) % 2) == 0);
    return runin || (k >= b1s && k <= b1e) || (k >= b2s && k <= b2e);
  endfunction

  // Called right after a negedge. One line: sync falls on edge 0.
  task automatic run_line(input int sel, input int meth, input int n, input int len,
                          input int b1s, input int b1e, input int b2s, input int b2e,
                          input int chg_at, input int nsel, input int nmeth, input int nn,
                          input string tag);
    int m_cnt = 0;
    bit m_armed = 0, m_prev = 0, m_found = 0, prevc, c, fall, old_armed, hitv;
    int m_f = -1;
    bit e_found, e_dclk;
    obs_found_k = -1; obs_dclk_k = -1; obs_dclk_n = 0;
    pulse_sel_i = 3'(sel); method_i = meth[0]; delay_i = DW'(n);
    hsync_i = 1'b0;
    cmp_i = cmp_at(0, b1s, b1e, b2s, b2e);
    prevc = cmp_i;
    for (int k = 0; k <= len; k++) begin
      @(posedge clk);
      if (k > 0) begin
        c = cmp_at(k, b1s, b1e, b2s, b2e);
        fall = prevc && !c;
        old_armed = m_armed;
        if ((k % 13) == 0 && old_armed && !m_found) begin
          hitv = c && (meth == 0 || m_prev);
          m_prev = c;
          if (hitv) begin m_found = 1; m_f = k; end
        end
        if (fall) begin
          if (sel != 0 && m_cnt + 1 == sel && !m_armed) m_armed = 1;
          if (m_cnt < 7) m_cnt++;
        end
        prevc = c;
      end
      e_found = m_found;
      e_dclk = m_found && (k >= m_f + 13 + n) && (((k - m_f - 13 - n) % 13) == 0);
      @(negedge clk);
      chk({tag, " R4 R5 R11"}, $sformatf("start_found_o at k=%0d", k), int'(start_found_o), int'(e_found));
      chk({tag, " R7 R8"}, $sformatf("dclk_o at k=%0d", k), int'(dclk_o), int'(e_dclk));
      if (k == 0) begin obs_k0_found = int'(start_found_o); obs_k0_dclk = int'(dclk_o); end
      if (start_found_o && obs_found_k < 0) obs_found_k = k;
      if (dclk_o) begin
        obs_dclk_n++;
        if (obs_dclk_k < 0) obs_dclk_k = k;
      end
      cmp_i = cmp_at(k + 1, b1s, b1e, b2s, b2e);
      hsync_i = (k + 1 >= 3);
      if (k + 1 == chg_at) begin
        pulse_sel_i = 3'(nsel); method_i = nmeth[0]; delay_i = DW'(nn);
      end
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; hsync_i = 1'b1; cmp_i = 1'b0;
    pulse_sel_i = 3'd3; method_i = 1'b0; delay_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "start_found_o in reset", int'(start_found_o), 0);
    chk("R1", "dclk_o in reset", int'(dclk_o), 0);
    rst_n = 1'b1;
    repeat (20) begin
      @(negedge clk);
      cmp_i = ~cmp_i;
    end
    cmp_i = 1'b0;
    @(negedge clk);
    chk("R1", "start_found_o before first sync", int'(start_found_o), 0);
    chk("R1", "dclk_o before first sync", int'(dclk_o), 0);
  endtask

  task automatic t_pulse_select;
    run_line(3, 0, 2, 60, -1, -1, -1, -1, -1, 0, 0, 0, "R2");
    chk("R2 R4", "found edge, pulse 3", obs_found_k, 13);
    chk("R7", "first dclk, N=2", obs_dclk_k, 28);
    run_line(5, 0, 2, 60, -1, -1, -1, -1, -1, 0, 0, 0, "R2");
    chk("R2 R3", "found edge, pulse 5", obs_found_k, 26);
    chk("R7", "first dclk after pulse 5", obs_dclk_k, 41);
  endtask

  task automatic t_methods;
    run_line(1, 1, 0, 50, -1, -1, -1, -1, -1, 0, 0, 0, "R5");
    chk("R5", "two-sample found edge", obs_found_k, 26);
    chk("R7", "first dclk, N=0", obs_dclk_k, 39);
    run_line(7, 1, 1, 100, 39, 39, 60, 80, -1, 0, 0, 0, "R5");
    chk("R5", "glitch rejected, found edge", obs_found_k, 78);
    chk("R7", "first dclk, N=1", obs_dclk_k, 92);
    run_line(7, 0, 1, 100, 39, 39, 60, 80, -1, 0, 0, 0, "R4");
    chk("R4", "single-sample found edge on glitch", obs_found_k, 39);
  endtask

  task automatic t_idle;
    run_line(0, 0, 0, 60, 30, 50, -1, -1, -1, 0, 0, 0, "R6");
    chk("R6", "found never set with select 0", obs_found_k, -1);
    chk("R6", "no dclk with select 0", obs_dclk_n, 0);
  endtask

  task automatic t_shadow;
    run_line(7, 0, 3, 70, 39, 39, -1, -1, 5, 1, 1, 0, "R9");
    chk("R9", "mid-line write ignored, found edge", obs_found_k, 39);
    chk("R9", "mid-line delay write ignored", obs_dclk_k, 55);
    run_line(1, 1, 0, 50, 39, 39, -1, -1, -1, 0, 0, 0, "R9");
    chk("R9", "write active on next line, found edge", obs_found_k, 26);
  endtask

  task automatic t_delay_max;
    run_line(3, 0, 15, 70, -1, -1, -1, -1, -1, 0, 0, 0, "R7");
    chk("R7", "first dclk, N=15", obs_dclk_k, 41);
    chk("R8", "dclk pulses in line", obs_dclk_n, 3);
  endtask

  task automatic t_collision;
    run_line(3, 0, 2, 53, -1, -1, -1, -1, -1, 0, 0, 0, "R10");
    chk("R8", "dclk pulses before sync", obs_dclk_n, 2);
    run_line(0, 0, 0, 20, -1, -1, -1, -1, -1, 0, 0, 0, "R10");
    chk("R10", "dclk due on sync edge suppressed", obs_k0_dclk, 0);
    chk("R10", "found cleared on sync edge", obs_k0_found, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_pulse_select();
    t_methods();
    t_idle();
    t_shadow();
    t_delay_max();
    t_collision();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule